// File: doc/BRIEF.md
# GPIO Controller with Interrupt Routing

This block is a register-mapped general-purpose I/O controller for 22 pins. Software reaches it through a plain 32-bit port: one address, a write strobe, write data and combinational read data. Through this port it sets which pins drive their pads and what value they drive, and it samples the pad levels. Every pad input passes through a two-flop synchronizer before any logic uses it.

A fixed window of six pins, starting at pin 8, can also raise interrupts. Each pin in the window owns a two-bit function-select field. When the low bit of that field is set, the synchronized pin level goes through a per-line polarity stage and appears on a dedicated request line. The request is active-high whichever pad polarity is configured. The request is a plain level with no internal latch. Masking, acknowledge and edge capture are the job of the upstream interrupt controller.

Software edits single bits by read-modify-write. Every writable register therefore returns exactly what was last written to its implemented bits.

Top module: `gpio_irq_router`

## Requirements
- R1: While reset is applied, and on release, every register reads 0 and pad_oe, pad_out and irq_req are all 0.
- R2: The polarity (0x290), output-enable (0x29C) and output-data (0x2A0) registers read back the last written value in bits 21:0 and read 0 in bits 31:22. The select register (0x294) reads back all 32 written bits.
- R3: pad_oe[n] equals bit n of the output-enable register, and pad_out[n] equals bit n of the output-data register, one clock after the write.
- R4: The input register (0x2A4) shows pad_in in bits 21:0 after exactly two clock edges, including pins that are driven as outputs. Writes to 0x2A4 change nothing.
- R5: irq_req[k] serves pin k+8. It is 0 whenever select bit 2*(k+8) is clear, whatever the pin level.
- R6: With select bit 2*(k+8) set, irq_req[k] is 1 exactly when the synchronized pin k+8 equals polarity bit k. Polarity 1 means active-high and polarity 0 means active-low, and the output itself is always active-high.
- R7: Odd select bits, and select bits of pins outside 8..13, have no effect on any irq_req line.
- R8: Reads of any offset other than the five listed return 0. Writes to such offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 12 | Byte offset for both reads and writes |
| bus_wen | input | 1 | Write strobe, one write per cycle while high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | 22 | Pad input levels, asynchronous |
| pad_out | output | 22 | Pad output values |
| pad_oe | output | 22 | Pad drive enables, 1 = driven |
| irq_req | output | 6 | Active-high interrupt requests, line k for pin k+8 |

## Verification
The bench aims at the polarity inversion. A design that passed the raw level upstream would raise active-low lines while the pin is idle. It also checks select-bit placement: odd bits and bits of pins just outside the window (pins 3 and 14) are set with the pads active, and a design that used the wrong bit index would raise a spurious request. Synchronizer latency is measured one edge and two edges after a pad change, which catches a stage too many or too few. Writes to the input register and to unmapped offsets are followed by a full readback, so aliasing in the decoder shows up as a corrupted register.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_POL = 12'h290;
  localparam logic [ADDR_W-1:0] OFS_SEL = 12'h294;
  localparam logic [ADDR_W-1:0] OFS_OE  = 12'h29C;
  localparam logic [ADDR_W-1:0] OFS_OUT = 12'h2A0;
  localparam logic [ADDR_W-1:0] OFS_IN  = 12'h2A4;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_POL,
    REG_SEL,
    REG_OE,
    REG_OUT,
    REG_IN
  } reg_id_e;

  function automatic reg_id_e decode_ofs(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_POL: return REG_POL;
      OFS_SEL: return REG_SEL;
      OFS_OE:  return REG_OE;
      OFS_OUT: return REG_OUT;
      OFS_IN:  return REG_IN;
      default: return REG_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_in;
      stab_q <= meta_q;
    end
  end

  assign sync_out = stab_q;

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 22,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_PINS-1:0] pin_lvl,
  output logic [NUM_PINS-1:0] pol_q,
  output logic [DATA_W-1:0]   sel_q,
  output logic [NUM_PINS-1:0] oe_q,
  output logic [NUM_PINS-1:0] out_q
);

  reg_id_e id;
  logic    pol_en, sel_en, oe_en, out_en;
  logic [NUM_PINS-1:0] pin_d;

  always_comb begin
    id     = decode_ofs(bus_addr);
    pol_en = bus_wen && (id == REG_POL);
    sel_en = bus_wen && (id == REG_SEL);
    oe_en  = bus_wen && (id == REG_OE);
    out_en = bus_wen && (id == REG_OUT);
    pin_d  = bus_wdata[NUM_PINS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pol_q <= '0;
    else if (pol_en) pol_q <= pin_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_en) sel_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     oe_q <= '0;
    else if (oe_en) oe_q <= pin_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (out_en) out_q <= pin_d;
  end

  always_comb begin
    bus_rdata = '0;
    case (id)
      REG_POL: bus_rdata[NUM_PINS-1:0] = pol_q;
      REG_SEL: bus_rdata               = sel_q;
      REG_OE:  bus_rdata[NUM_PINS-1:0] = oe_q;
      REG_OUT: bus_rdata[NUM_PINS-1:0] = out_q;
      REG_IN:  bus_rdata[NUM_PINS-1:0] = pin_lvl;
      default: bus_rdata               = '0;
    endcase
  end

endmodule

// File: rtl/gpio_irq_map.sv
module gpio_irq_map #(
  parameter int NUM_IRQ = 6
) (
  input  logic [NUM_IRQ-1:0] en_win,
  input  logic [NUM_IRQ-1:0] lvl_win,
  input  logic [NUM_IRQ-1:0] pol_win,
  output logic [NUM_IRQ-1:0] irq
);

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_line
    // polarity 1: high level requests; polarity 0: low level requests
    assign irq[k] = en_win[k] & ~(lvl_win[k] ^ pol_win[k]);
  end

endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 22,
  parameter int NUM_IRQ  = 6,
  parameter int IRQ_BASE = 8,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wen,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_IRQ-1:0]  irq_req
);

  localparam int SEL_BITS = 2;

  logic                rst_core_n;
  logic [NUM_PINS-1:0] pin_lvl;
  logic [NUM_PINS-1:0] pol_q;
  logic [DATA_W-1:0]   sel_q;
  logic [NUM_PINS-1:0] oe_q;
  logic [NUM_PINS-1:0] out_q;
  logic [NUM_IRQ-1:0]  en_win, lvl_win, pol_win;

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .async_in (pad_in),
    .sync_out (pin_lvl)
  );

  gpio_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .bus_addr  (bus_addr),
    .bus_wen   (bus_wen),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_lvl   (pin_lvl),
    .pol_q     (pol_q),
    .sel_q     (sel_q),
    .oe_q      (oe_q),
    .out_q     (out_q)
  );

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_win
    localparam int PIN = IRQ_BASE + k;
    assign en_win[k]  = sel_q[SEL_BITS*PIN];
    assign lvl_win[k] = pin_lvl[PIN];
    assign pol_win[k] = pol_q[k];
  end

  gpio_irq_map #(.NUM_IRQ(NUM_IRQ)) u_map (
    .en_win  (en_win),
    .lvl_win (lvl_win),
    .pol_win (pol_win),
    .irq     (irq_req)
  );

  assign pad_out = out_q;
  assign pad_oe  = oe_q;

endmodule

// File: rtl/gpio_irq_router_chk.sv
module gpio_irq_router_chk
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 22,
  parameter int NUM_IRQ  = 6,
  parameter int IRQ_BASE = 8,
  parameter int DATA_W   = 32
) (
  input logic                clk,
  input logic                rst_core_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_wen,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [NUM_PINS-1:0] pad_in,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_IRQ-1:0]  irq_req,
  input logic [DATA_W-1:0]   sel_q
);

  logic [1:0]         warm_q;
  logic [NUM_IRQ-1:0] win_en;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)         warm_q <= '0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_en
    assign win_en[k] = sel_q[2*(IRQ_BASE+k)];
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_core_n |-> (pad_oe == '0 && pad_out == '0 && irq_req == '0));

  a_r2_sel_store: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_wen && bus_addr == OFS_SEL) |=> sel_q == $past(bus_wdata));

  a_r3_oe_write: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_wen && bus_addr == OFS_OE) |=> pad_oe == $past(bus_wdata[NUM_PINS-1:0]));

  a_r3_oe_hold: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(bus_wen && bus_addr == OFS_OE) |=> $stable(pad_oe));

  a_r4_in_latency: assert property (@(posedge clk) disable iff (!rst_core_n)
    (warm_q == 2'd2 && bus_addr == OFS_IN) |->
      bus_rdata == DATA_W'($past(pad_in, 2)));

  a_r5_gated: assert property (@(posedge clk) disable iff (!rst_core_n)
    (irq_req & ~win_en) == '0);

  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_core_n)
    (decode_ofs(bus_addr) == REG_NONE) |-> bus_rdata == '0);

endmodule

bind gpio_irq_router gpio_irq_router_chk #(
  .NUM_PINS (NUM_PINS),
  .NUM_IRQ  (NUM_IRQ),
  .IRQ_BASE (IRQ_BASE),
  .DATA_W   (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .bus_addr   (bus_addr),
  .bus_wen    (bus_wen),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .pad_in     (pad_in),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .irq_req    (irq_req),
  .sel_q      (sel_q)
);

// File: tb/gpio_irq_router_bench.sv
`timescale 1ns/100ps
module gpio_irq_router_bench;

  localparam int NP = 22;
  localparam int NI = 6;
  localparam int IB = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_wen;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pad_in;
  logic [NP-1:0] pad_out;
  logic [NP-1:0] pad_oe;
  logic [NI-1:0] irq_req;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [31:0] pol_m, sel_m, oe_m, out_m;

  always #2.5 clk = ~clk;

  gpio_irq_router u_gpio_irq_router (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_req(irq_req)
  );

  function automatic bit is_mapped(input logic [11:0] a);
    return a == 12'h290 || a == 12'h294 || a == 12'h29C ||
           a == 12'h2A0 || a == 12'h2A4;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    case (a)
      12'h290: return pol_m;
      12'h294: return sel_m;
      12'h29C: return oe_m;
      12'h2A0: return out_m;
      12'h2A4: return {10'd0, pad_in};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [NI-1:0] exp_irq();
    logic [NI-1:0] r;
    for (int k = 0; k < NI; k++)
      r[k] = sel_m[2*(IB+k)] && (pad_in[IB+k] == pol_m[k]);
    return r;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    tick(1);
    bus_wen = 1'b0;
    case (a)
      12'h290: pol_m = d & 32'h003F_FFFF;
      12'h294: sel_m = d;
      12'h29C: oe_m  = d & 32'h003F_FFFF;
      12'h2A0: out_m = d & 32'h003F_FFFF;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic check_all(input logic [11:0] extra);
    logic [31:0] v;
    rd(12'h290, v); chk("R2", "polarity", v, exp_rd(12'h290));
    rd(12'h294, v); chk("R2", "select",   v, exp_rd(12'h294));
    rd(12'h29C, v); chk("R2", "oe reg",   v, exp_rd(12'h29C));
    rd(12'h2A0, v); chk("R2", "out reg",  v, exp_rd(12'h2A0));
    rd(12'h2A4, v); chk("R4", "in reg",   v, exp_rd(12'h2A4));
    rd(extra, v);   chk("R8", "unmapped read", v, exp_rd(extra));
    chk("R3", "pad_oe",  {10'd0, pad_oe},  oe_m);
    chk("R3", "pad_out", {10'd0, pad_out}, out_m);
    chk("R6", "irq_req", {26'd0, irq_req}, {26'd0, exp_irq()});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [11:0] ua;
    void'($urandom(32'd20240611));
    pol_m = '0; sel_m = '0; oe_m = '0; out_m = '0;
    rst_n = 1'b0; bus_addr = '0; bus_wen = 1'b0; bus_wdata = '0; pad_in = '0;
    tick(3);
    // R1: state while reset is applied
    chk("R1", "pad_oe in reset",  {10'd0, pad_oe}, 32'd0);
    chk("R1", "pad_out in reset", {10'd0, pad_out}, 32'd0);
    chk("R1", "irq in reset",     {26'd0, irq_req}, 32'd0);
    rst_n = 1'b1;
    tick(4);
    check_all(12'h000); // R1: all zero after release

    // R2: all-ones readback, upper bits dropped except select
    wr(12'h290, 32'hFFFF_FFFF); wr(12'h294, 32'hFFFF_FFFF);
    wr(12'h29C, 32'hFFFF_FFFF); wr(12'h2A0, 32'hFFFF_FFFF);
    rd(12'h290, v); chk("R2", "pol upper bits", v, 32'h003F_FFFF);
    rd(12'h294, v); chk("R2", "sel all bits",   v, 32'hFFFF_FFFF);
    check_all(12'h298);

    // R4: two-edge latency, also on driven pins
    wr(12'h294, 32'h0); wr(12'h290, 32'h0);
    pad_in = 22'h2A_5A5A;
    tick(1); rd(12'h2A4, v); chk("R4", "after one edge", v, 32'd0);
    tick(1); rd(12'h2A4, v); chk("R4", "after two edges", v, 32'h002A_5A5A);
    wr(12'h2A4, 32'h0000_1234); tick(2);
    check_all(12'h2A8); // R4: input write ignored

    // R6: polarity on line 0 (pin 8, select bit 16)
    pad_in = '0; wr(12'h294, 32'h0001_0000); wr(12'h290, 32'h1); tick(2);
    chk("R6", "active-high idle", {26'd0, irq_req}, 32'd0);
    pad_in[8] = 1'b1; tick(2);
    chk("R6", "active-high asserted", {26'd0, irq_req}, 32'd1);
    wr(12'h290, 32'h0);
    chk("R6", "active-low with high pin", {26'd0, irq_req}, 32'd0);
    pad_in[8] = 1'b0; tick(2);
    chk("R6", "active-low asserted", {26'd0, irq_req}, 32'd1);
    // R5: deselect with active level present
    wr(12'h294, 32'h0);
    chk("R5", "deselected line", {26'd0, irq_req}, 32'd0);

    // R7: odd bits and neighbours outside the window
    pad_in = '1; wr(12'h290, 32'h3F);
    wr(12'h294, 32'hAAAA_AAAA | 32'h1000_0000 | 32'h0000_0040); tick(2);
    chk("R7", "stray select bits", {26'd0, irq_req}, 32'd0);
    check_all(12'h2FC);

    // R8: unmapped writes leave everything intact
    wr(12'h298, 32'hFFFF_FFFF); wr(12'h000, 32'hFFFF_FFFF);
    wr(12'h2A8, 32'hFFFF_FFFF); wr(12'h28C, 32'hFFFF_FFFF);
    check_all(12'h28C);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom % 5);
      case (op)
        0: wr(12'h290, $urandom);
        1: wr(12'h294, $urandom);
        2: begin
          int r;
          r = int'($urandom % 3);
          wr(r == 0 ? 12'h29C : (r == 1 ? 12'h2A0 : 12'h2A4), $urandom);
        end
        3: begin
          ua = 12'($urandom);
          while (is_mapped(ua)) ua = ua + 12'd4;
          wr(ua, $urandom);
        end
        default: pad_in = NP'($urandom);
      endcase
      tick(2);
      ua = 12'($urandom);
      while (is_mapped(ua)) ua = ua + 12'd1;
      check_all(ua);
    end
    finish_run();
  end

endmodule